// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block lets software drive a serial NOR flash through a single 32-bit command word. Software writes a word with one trigger bit set. Each trigger bit names a complete flash operation: read, write enable, write disable, identification read, status read or write, page program, sector, block or chip erase, power down, wake-up, high-performance entry, or a command defined by software. The sequencer decodes the trigger into an opcode and a set of phases, and then moves through them on a single-bit SPI link in mode 0. The phases are command, 24-bit address, wait, read data and write data. Each operation includes only the phases it needs.

While the operation runs, the same word reads back the sequencer's phase code and the bit-engine's status. When the operation ends, hardware clears the trigger bits, so software detects completion by polling them. The address, the data length, the user-command settings and the write data are plain inputs. Write data is fetched through a byte index output. Received bytes leave on a strobed byte output.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the command word reads 0x00000000, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: Read-back bits 7:4 give the sequencer phase (0 idle, 1 prepare, 2 command, 3 address, 4 wait, 5 read data, 6 write data, 7 done, 8 read-data end). Bits 3:0 give the bit-engine status (0 idle, 1 shifting with SCLK low, 2 shifting with SCLK high). Bits 16:8 read 0.
- R3: Each trigger bit sends its opcode MSB first: bit 31 0x03, 30 0x06, 29 0x04, 28 0x9F, 27 0x05, 26 0x01, 25 0x02, 24 0x20, 23 0x52, 22 0xC7, 21 0xB9, 20 0xAB, 19 0xA3, 18 `usr_opcode`.
- R4: When the operation completes, all trigger bits and bit 17 clear together. `spi_cs_n` returns high on the same clock.
- R5: When several trigger bits are written at once, only the highest-numbered one runs.
- R6: A write to the command word is ignored while an operation is pending or running.
- R7: Read (bit 31), page program (25), sector erase (24) and block erase (23) send `op_addr` as 3 bytes, high byte first, right after the opcode. The other fixed operations send no address.
- R8: A read returns `op_len_m1`+1 bytes, read ID returns 3 bytes and read status returns 1 byte. Each byte appears on `rd_byte` with a one-cycle `rd_valid`. A read passes through the read-data-end phase.
- R9: Page program sends `op_len_m1`+1 bytes (1 to 256). Write status sends 1 byte. Byte k is taken from `wr_byte` while `wr_idx` equals k.
- R10: SPI mode 0. SCLK is low whenever CS_n is high, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R11: CS_n falls at least one SCLK half period before the first rising edge. After the last falling edge it stays low for at least one full SCLK period, spent in the done phase.
- R12: The user command (bit 18) sends `usr_opcode`. It then sends the address if `usr_addr_en` is set, and then `usr_dummy` SCLK cycles in the wait phase. If `usr_data_en` is set it transfers `op_len_m1`+1 bytes, written when `usr_data_wr` is 1 and read when it is 0.
- R13: Bit 17 (program/erase marker) is stored only when bit 18 is set in the same write, and it clears at completion. Written alone, it is dropped and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word write data |
| cmd_rdata | output | 32 | Command word read-back with triggers and status |
| op_addr | input | 24 | Flash address for operations with an address phase |
| op_len_m1 | input | 8 | Data byte count minus one |
| usr_opcode | input | 8 | Opcode of the user command |
| usr_addr_en | input | 1 | User command includes an address phase |
| usr_dummy | input | 4 | Wait-phase SCLK cycles for the user command |
| usr_data_en | input | 1 | User command includes a data phase |
| usr_data_wr | input | 1 | User data phase direction, 1 write and 0 read |
| wr_idx | output | 8 | Index of the write byte the sequencer wants |
| wr_byte | input | 8 | Write data byte for the current index |
| rd_byte | output | 8 | Received data byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_byte` |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check the link rules on every cycle: SCLK low while idle or deselected, MOSI stable while SCLK is high, CS_n low exactly while the sequencer is not idle, and a legal phase code. They also check that the command word does not move when written during a busy period, that the marker bit never stands without the user bit, and that every field clears at completion. Only the bench scenarios show that each trigger produces the right opcode, address, byte count and data order against a flash model, that the highest trigger wins, and that the 256-byte program and the user-command variants emit the right frames. The bench also measures the chip-select margins in time.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_PREP  = 4'd1,
    ST_CMD   = 4'd2,
    ST_ADDR  = 4'd3,
    ST_WAIT  = 4'd4,
    ST_RD    = 4'd5,
    ST_WR    = 4'd6,
    ST_DONE  = 4'd7,
    ST_RDEND = 4'd8
  } seq_state_e;

  localparam int TRIG_LSB  = 18;
  localparam int TRIG_MSB  = 31;
  localparam int NUM_TRIG  = TRIG_MSB - TRIG_LSB + 1;
  localparam int SEL_W     = $clog2(NUM_TRIG);
  localparam int MARK_POS  = 17;
  localparam int LEN_W     = 8;
  localparam int CNT_W     = LEN_W + 1;
  localparam int ADDR_BYTES = 3;

  // trigger index = word bit - TRIG_LSB
  localparam int IX_USER  = 0;
  localparam int IX_HPM   = 1;
  localparam int IX_WAKE  = 2;
  localparam int IX_SLEEP = 3;
  localparam int IX_CHIP  = 4;
  localparam int IX_BLK   = 5;
  localparam int IX_SEC   = 6;
  localparam int IX_PROG  = 7;
  localparam int IX_WSTAT = 8;
  localparam int IX_RSTAT = 9;
  localparam int IX_RID   = 10;
  localparam int IX_WDIS  = 11;
  localparam int IX_WEN   = 12;
  localparam int IX_READ  = 13;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_WDIS  = 8'h04;
  localparam logic [7:0] OPC_RID   = 8'h9F;
  localparam logic [7:0] OPC_RSTAT = 8'h05;
  localparam logic [7:0] OPC_WSTAT = 8'h01;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_SEC   = 8'h20;
  localparam logic [7:0] OPC_BLK   = 8'h52;
  localparam logic [7:0] OPC_CHIP  = 8'hC7;
  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_WAKE  = 8'hAB;
  localparam logic [7:0] OPC_HPM   = 8'hA3;

  typedef struct packed {
    logic [7:0]       opcode;
    logic             use_addr;
    logic [3:0]       dummy;
    logic             rd;
    logic             wr;
    logic [CNT_W-1:0] nbytes;
  } op_desc_t;

endpackage

// File: rtl/fcs_cmd_reg.sv
module fcs_cmd_reg
  import fcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [31:0]         wdata,
  input  logic                busy,
  input  logic                clr,
  output logic [NUM_TRIG-1:0] trig,
  output logic                mark,
  output logic                any,
  output logic [SEL_W-1:0]    sel
);

  logic accept;
  assign accept = wr_en && !busy && !any;
  assign any    = |trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig <= '0;
      mark <= 1'b0;
    end else if (clr) begin
      trig <= '0;
      mark <= 1'b0;
    end else if (accept) begin
      trig <= wdata[TRIG_MSB:TRIG_LSB];
      mark <= wdata[MARK_POS] & wdata[TRIG_LSB];
    end
  end

  // ascending scan: the last set bit found is the highest and wins
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (trig[i]) sel = i[SEL_W-1:0];
    end
  end

  // R6: a write while pending or busy leaves the command word unchanged
  a_r6_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (busy || any) && !clr) |=> $stable(trig) && $stable(mark));

  // R13: the marker never stands without the user trigger
  a_r13_mark_needs_user: assert property (@(posedge clk) disable iff (rst)
    mark |-> trig[IX_USER]);

  // R4: completion clears every field
  a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr |=> (trig == '0) && !mark);

endmodule

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [7:0]       usr_opcode,
  input  logic             usr_addr_en,
  input  logic [3:0]       usr_dummy,
  input  logic             usr_data_en,
  input  logic             usr_data_wr,
  output op_desc_t         desc
);

  logic [CNT_W-1:0] len_cnt;
  assign len_cnt = {1'b0, len_m1} + CNT_W'(1);

  always_comb begin
    desc = '0;
    case (int'(sel))
      IX_READ:  begin desc.opcode = OPC_READ;  desc.use_addr = 1'b1;
                      desc.rd = 1'b1; desc.nbytes = len_cnt; end
      IX_WEN:   desc.opcode = OPC_WEN;
      IX_WDIS:  desc.opcode = OPC_WDIS;
      IX_RID:   begin desc.opcode = OPC_RID;   desc.rd = 1'b1;
                      desc.nbytes = CNT_W'(3); end
      IX_RSTAT: begin desc.opcode = OPC_RSTAT; desc.rd = 1'b1;
                      desc.nbytes = CNT_W'(1); end
      IX_WSTAT: begin desc.opcode = OPC_WSTAT; desc.wr = 1'b1;
                      desc.nbytes = CNT_W'(1); end
      IX_PROG:  begin desc.opcode = OPC_PROG;  desc.use_addr = 1'b1;
                      desc.wr = 1'b1; desc.nbytes = len_cnt; end
      IX_SEC:   begin desc.opcode = OPC_SEC;   desc.use_addr = 1'b1; end
      IX_BLK:   begin desc.opcode = OPC_BLK;   desc.use_addr = 1'b1; end
      IX_CHIP:  desc.opcode = OPC_CHIP;
      IX_SLEEP: desc.opcode = OPC_SLEEP;
      IX_WAKE:  desc.opcode = OPC_WAKE;
      IX_HPM:   desc.opcode = OPC_HPM;
      default: begin
        desc.opcode   = usr_opcode;
        desc.use_addr = usr_addr_en;
        desc.dummy    = usr_dummy;
        desc.rd       = usr_data_en & ~usr_data_wr;
        desc.wr       = usr_data_en & usr_data_wr;
        desc.nbytes   = usr_data_en ? len_cnt : '0;
      end
    endcase
  end

endmodule

// File: rtl/fcs_shifter.sv
module fcs_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic [3:0] nbits,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       done,
  output logic [3:0] mst_st
);

  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             active;
  logic [DIV_W-1:0] divcnt;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      divcnt <= '0;
      bitcnt <= '0;
      sh     <= '0;
      rx     <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sh     <= tx;
        mosi   <= tx[7];
        bitcnt <= nbits;
        divcnt <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (divcnt == DIV_LAST) begin
          divcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk   <= 1'b0;
            bitcnt <= bitcnt - 4'd1;
            if (bitcnt == 4'd1) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          divcnt <= divcnt + DIV_W'(1);
        end
      end
    end
  end

  assign mst_st = !active ? 4'd0 : (sclk ? 4'd2 : 4'd1);

  // R10: the clock rests low outside a transfer
  a_r10_sclk_rest_low: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);

  // R10: data never moves while the clock is high
  a_r10_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  op_desc_t    desc_in,
  input  logic [23:0] addr,
  input  logic [7:0]  wr_byte,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  output seq_state_e  state,
  output logic        cs_n,
  output logic        sh_start,
  output logic [7:0]  sh_tx,
  output logic [3:0]  sh_nbits,
  output logic [7:0]  rd_byte,
  output logic        rd_valid,
  output logic [7:0]  wr_idx,
  output logic        op_done
);

  localparam int DWELL   = 2 * HALF_DIV;
  localparam int DWELL_W = $clog2(DWELL + 1);
  localparam int ACNT_W  = $clog2(ADDR_BYTES + 1);

  op_desc_t          desc;
  logic [23:0]       addr_q;
  logic [ACNT_W-1:0] addr_cnt;
  logic [CNT_W-1:0]  byte_cnt;
  logic [DWELL_W-1:0] dwell;

  seq_state_e after_wait, after_addr, after_cmd, tgt;
  logic [ACNT_W-1:0] aidx;
  logic [7:0]        l_tx;
  logic [3:0]        l_bits;

  always_comb begin
    after_wait = (desc.nbytes != '0 && desc.rd) ? ST_RD :
                 (desc.nbytes != '0 && desc.wr) ? ST_WR : ST_DONE;
    after_addr = (desc.dummy != '0) ? ST_WAIT : after_wait;
    after_cmd  = desc.use_addr ? ST_ADDR : after_addr;
    case (state)
      ST_CMD:  tgt = after_cmd;
      ST_ADDR: tgt = (addr_cnt == ACNT_W'(ADDR_BYTES)) ? after_addr : ST_ADDR;
      ST_WAIT: tgt = after_wait;
      ST_RD:   tgt = (byte_cnt == CNT_W'(1)) ? ST_RDEND : ST_RD;
      ST_WR:   tgt = (byte_cnt == CNT_W'(1)) ? ST_DONE : ST_WR;
      default: tgt = state;
    endcase
    aidx = (state == ST_CMD) ? '0 : addr_cnt;
    l_bits = 4'd8;
    l_tx   = 8'h00;
    case (tgt)
      ST_ADDR: begin
        case (int'(aidx))
          0:       l_tx = addr_q[23:16];
          1:       l_tx = addr_q[15:8];
          default: l_tx = addr_q[7:0];
        endcase
      end
      ST_WAIT: l_bits = desc.dummy;
      ST_WR:   l_tx   = wr_byte;
      default: ;
    endcase
  end

  assign op_done = (state == ST_DONE) && (dwell == DWELL_W'(DWELL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      desc     <= '0;
      addr_q   <= '0;
      addr_cnt <= '0;
      byte_cnt <= '0;
      dwell    <= '0;
      sh_start <= 1'b0;
      sh_tx    <= '0;
      sh_nbits <= '0;
      rd_byte  <= '0;
      rd_valid <= 1'b0;
      wr_idx   <= '0;
    end else begin
      sh_start <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            desc     <= desc_in;
            addr_q   <= addr;
            addr_cnt <= '0;
            wr_idx   <= '0;
            cs_n     <= 1'b0;
            state    <= ST_PREP;
          end
        end
        ST_PREP: begin
          sh_start <= 1'b1;
          sh_tx    <= desc.opcode;
          sh_nbits <= 4'd8;
          state    <= ST_CMD;
        end
        ST_CMD, ST_ADDR, ST_WAIT, ST_RD, ST_WR: begin
          if (sh_done) begin
            if (state == ST_RD) begin
              rd_valid <= 1'b1;
              rd_byte  <= sh_rx;
            end
            state <= tgt;
            if (tgt == ST_DONE) begin
              dwell <= '0;
            end else if (tgt != ST_RDEND) begin
              sh_start <= 1'b1;
              sh_tx    <= l_tx;
              sh_nbits <= l_bits;
            end
            if (tgt == ST_ADDR) addr_cnt <= addr_cnt + ACNT_W'(1);
            if (tgt == ST_WR)   wr_idx   <= wr_idx + 8'd1;
            if (tgt != state) byte_cnt <= desc.nbytes;
            else              byte_cnt <= byte_cnt - CNT_W'(1);
          end
        end
        ST_RDEND: begin
          dwell <= '0;
          state <= ST_DONE;
        end
        ST_DONE: begin
          if (op_done) begin
            cs_n  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            dwell <= dwell + DWELL_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: the chip is selected exactly while the sequencer is away from idle
  a_r11_select_span: assert property (@(posedge clk) disable iff (rst)
    cs_n == (state == ST_IDLE));

  // R8: the read-data-end phase only follows the read-data phase
  a_r8_end_after_read: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDEND) |-> ($past(state) == ST_RD));

  // R2: the phase code stays inside the documented set
  a_r2_legal_phase: assert property (@(posedge clk) disable iff (rst)
    state <= ST_RDEND);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  input  logic [23:0] op_addr,
  input  logic [7:0]  op_len_m1,
  input  logic [7:0]  usr_opcode,
  input  logic        usr_addr_en,
  input  logic [3:0]  usr_dummy,
  input  logic        usr_data_en,
  input  logic        usr_data_wr,
  output logic [7:0]  wr_idx,
  input  logic [7:0]  wr_byte,
  output logic [7:0]  rd_byte,
  output logic        rd_valid,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  logic [NUM_TRIG-1:0] trig;
  logic                mark, any, op_done, busy, go;
  logic [SEL_W-1:0]    sel;
  op_desc_t            desc;
  seq_state_e          state;
  logic                sh_start, sh_done;
  logic [7:0]          sh_tx, sh_rx;
  logic [3:0]          sh_nbits, mst_st;

  assign busy = (state != ST_IDLE);
  assign go   = any && !busy;

  fcs_cmd_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(cmd_wr), .wdata(cmd_wdata),
    .busy(busy), .clr(op_done), .trig(trig), .mark(mark),
    .any(any), .sel(sel)
  );

  fcs_decode u_dec (
    .sel(sel), .len_m1(op_len_m1), .usr_opcode(usr_opcode),
    .usr_addr_en(usr_addr_en), .usr_dummy(usr_dummy),
    .usr_data_en(usr_data_en), .usr_data_wr(usr_data_wr), .desc(desc)
  );

  fcs_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst(rst), .go(go), .desc_in(desc), .addr(op_addr),
    .wr_byte(wr_byte), .sh_done(sh_done), .sh_rx(sh_rx), .state(state),
    .cs_n(spi_cs_n), .sh_start(sh_start), .sh_tx(sh_tx),
    .sh_nbits(sh_nbits), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .wr_idx(wr_idx), .op_done(op_done)
  );

  fcs_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .nbits(sh_nbits),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .rx(sh_rx),
    .done(sh_done), .mst_st(mst_st)
  );

  assign cmd_rdata = {trig, mark, 9'd0, state, mst_st};

  // R10: deselected link keeps its clock low
  a_r10_idle_clock: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/100ps
module sim_flash_cmd_seq;

  localparam int HALF = 2;
  localparam real TCLK = 5.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [23:0] op_addr = '0;
  logic [7:0]  op_len_m1 = '0;
  logic [7:0]  usr_opcode = '0;
  logic        usr_addr_en = 1'b0;
  logic [3:0]  usr_dummy = '0;
  logic        usr_data_en = 1'b0;
  logic        usr_data_wr = 1'b0;
  logic [7:0]  wr_idx, wr_byte, rd_byte;
  logic        rd_valid, spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #(TCLK/2) clk = ~clk;

  assign wr_byte = wr_idx * 8'd7 + 8'h31;

  flash_cmd_seq #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .op_addr(op_addr), .op_len_m1(op_len_m1),
    .usr_opcode(usr_opcode), .usr_addr_en(usr_addr_en),
    .usr_dummy(usr_dummy), .usr_data_en(usr_data_en),
    .usr_data_wr(usr_data_wr), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails = 0;

  function automatic logic [7:0] pat(int n);
    return 8'(n) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] wexp(int i);
    return 8'(i * 7 + 'h31);
  endfunction

  // flash model: collect MOSI bytes, drive a position pattern on MISO
  logic [7:0] mlog [0:299];
  logic [7:0] rlog [0:299];
  int nbyte = 0, nbit = 0, rises = 0, ntxn = 0, nrd = 0, glitch = 0;
  logic [7:0] shreg = '0;
  logic [15:0] seen = '0, mseen = '0;
  realtime t_csfall = 0, t_first = 0, t_fall = 0, t_csrise = 0;
  logic prev_sclk = 0, prev_mosi = 0;

  always @(negedge spi_cs_n) begin
    nbyte = 0; nbit = 0; rises = 0;
    t_csfall = $realtime;
    spi_miso = pat(0)[7];
  end
  always @(posedge spi_cs_n) begin
    ntxn++;
    t_csrise = $realtime;
  end
  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    if (rises == 0) t_first = $realtime;
    shreg = {shreg[6:0], spi_mosi};
    nbit++; rises++;
    if (nbit == 8) begin
      if (nbyte < 300) mlog[nbyte] = shreg;
      nbyte++; nbit = 0;
    end
  end
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin
    t_fall = $realtime;
    spi_miso = pat(nbyte)[7-nbit];
  end
  always @(posedge clk) if (!rst) begin
    if (rd_valid && nrd < 300) begin rlog[nrd] = rd_byte; nrd++; end
    seen[cmd_rdata[7:4]] = 1'b1;
    mseen[cmd_rdata[3:0]] = 1'b1;
  end
  always @(negedge clk) begin
    if (spi_sclk && prev_sclk && spi_mosi !== prev_mosi) glitch++;
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start_op(logic [31:0] v);
    nrd = 0; seen = '0; mseen = '0; glitch = 0;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic finish_op();
    int n = 0;
    while (cmd_rdata[31:17] != '0 && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 word", cmd_rdata, 32'h0);
    chk("R1 cs_n", 32'(spi_cs_n), 32'h1);
    chk("R1 sclk", 32'(spi_sclk), 32'h0);
  endtask

  task automatic t_wren();
    int t0 = ntxn;
    start_op(32'h4000_0000);
    finish_op();
    chk("R3 wren opcode", 32'(mlog[0]), 32'h06);
    chk("R3 wren bytes", nbyte, 1);
    chk("R4 cleared", cmd_rdata, 32'h0);
    chk("R4 one frame", ntxn - t0, 1);
  endtask

  task automatic t_read();
    op_addr = 24'h123456; op_len_m1 = 8'd3;
    start_op(32'h8000_0000);
    finish_op();
    chk("R3 read opcode", 32'(mlog[0]), 32'h03);
    chk("R7 addr", {8'h0, mlog[1], mlog[2], mlog[3]}, 32'h00123456);
    chk("R8 count", nrd, 4);
    for (int i = 0; i < 4; i++) chk("R8 data", 32'(rlog[i]), 32'(pat(4 + i)));
    chk("R2 phases read", 32'(seen & 16'h01FE), 32'h01AE);
    chk("R2 master codes", 32'(mseen), 32'h0007);
    chk("R10 mosi stable", glitch, 0);
    chk("R11 setup", 32'(t_first - t_csfall >= HALF * TCLK), 1);
    chk("R11 dwell", 32'(t_csrise - t_fall >= 2 * HALF * TCLK), 1);
  endtask

  task automatic t_prog(logic [7:0] lm1, logic [23:0] a);
    op_addr = a; op_len_m1 = lm1;
    start_op(32'h0200_0000);
    finish_op();
    chk("R3 prog opcode", 32'(mlog[0]), 32'h02);
    chk("R7 prog addr", {8'h0, mlog[1], mlog[2], mlog[3]}, 32'(a));
    chk("R9 prog bytes", nbyte, 4 + lm1 + 1);
    chk("R9 first", 32'(mlog[4]), 32'(wexp(0)));
    chk("R9 last", 32'(mlog[4 + lm1]), 32'(wexp(lm1)));
    chk("R2 phases prog", 32'(seen & 16'h01FE), 32'h00CE);
  endtask

  task automatic t_simple(int bitpos, logic [7:0] opc, int hdr);
    op_addr = 24'hA1B2C3;
    start_op(32'h1 << bitpos);
    finish_op();
    chk("R3 opcode", 32'(mlog[0]), 32'(opc));
    chk("R7 header bytes", nbyte, hdr);
    if (hdr == 4) chk("R7 addr hi", 32'(mlog[1]), 32'hA1);
  endtask

  task automatic t_status_id();
    start_op(32'h1000_0000);
    finish_op();
    chk("R3 rid opcode", 32'(mlog[0]), 32'h9F);
    chk("R8 rid count", nrd, 3);
    chk("R8 rid byte2", 32'(rlog[2]), 32'(pat(3)));
    start_op(32'h0800_0000);
    finish_op();
    chk("R3 rstat opcode", 32'(mlog[0]), 32'h05);
    chk("R8 rstat", {nrd[23:0], rlog[0]}, {24'd1, pat(1)});
    start_op(32'h0400_0000);
    finish_op();
    chk("R9 wstat", {nbyte[15:0], mlog[0], mlog[1]}, {16'd2, 8'h01, wexp(0)});
  endtask

  task automatic t_prio();
    int t0 = ntxn;
    start_op(32'h4020_0000);
    finish_op();
    chk("R5 winner", 32'(mlog[0]), 32'h06);
    chk("R5 single", {ntxn - t0, nbyte}, {32'd1, 32'd1});
    chk("R5 all clear", cmd_rdata, 32'h0);
  endtask

  task automatic t_busy();
    int t0 = ntxn;
    op_addr = 24'h000010; op_len_m1 = 8'd7;
    start_op(32'h8000_0000);
    repeat (20) @(negedge clk);
    chk("R6 pending", 32'(cmd_rdata[31:17]), 32'h4000);
    cmd_wr = 1'b1; cmd_wdata = 32'h0040_0000;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = '0;
    chk("R6 unchanged", 32'(cmd_rdata[31:17]), 32'h4000);
    finish_op();
    repeat (40) @(negedge clk);
    chk("R6 no second", ntxn - t0, 1);
    chk("R6 read ran", 32'(mlog[0]), 32'h03);
  endtask

  task automatic t_mark();
    int t0 = ntxn;
    start_op(32'h0002_0000);
    repeat (10) @(negedge clk);
    chk("R13 alone dropped", cmd_rdata, 32'h0);
    chk("R13 no frame", ntxn - t0, 0);
    usr_opcode = 8'hD8; usr_addr_en = 1'b0; usr_dummy = 4'd0; usr_data_en = 1'b0;
    start_op(32'h0006_0000);
    chk("R13 held", 32'(cmd_rdata[18:17]), 32'h3);
    finish_op();
    chk("R13 cleared", cmd_rdata, 32'h0);
    chk("R12 bare user", {nbyte[23:0], mlog[0]}, {24'd1, 8'hD8});
  endtask

  task automatic t_user();
    usr_opcode = 8'h35; usr_addr_en = 1'b0; usr_dummy = 4'd8;
    usr_data_en = 1'b1; usr_data_wr = 1'b0; op_len_m1 = 8'd1;
    start_op(32'h0004_0000);
    finish_op();
    chk("R12 edges", rises, 32);
    chk("R12 opcode", 32'(mlog[0]), 32'h35);
    chk("R12 rd", {nrd[15:0], rlog[0], rlog[1]}, {16'd2, pat(2), pat(3)});
    chk("R12 phases", 32'(seen & 16'h01FE), 32'h01B6);
    usr_opcode = 8'h32; usr_addr_en = 1'b1; usr_dummy = 4'd0;
    usr_data_wr = 1'b1; op_len_m1 = 8'd0; op_addr = 24'h000102;
    start_op(32'h0004_0000);
    finish_op();
    chk("R12 wr frame", {mlog[0], mlog[1], mlog[2], mlog[3]}, 32'h32000102);
    chk("R12 wr data", {nbyte[23:0], mlog[4]}, {24'd5, wexp(0)});
    usr_dummy = 4'd4; usr_addr_en = 1'b0; usr_data_en = 1'b0;
    start_op(32'h0004_0000);
    finish_op();
    chk("R12 dummy edges", rises, 12);
    usr_data_en = 1'b0; usr_data_wr = 1'b0; usr_dummy = '0;
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wren();
    t_read();
    t_prog(8'd2, 24'hABCDEF);
    t_prog(8'd255, 24'h000100);
    t_simple(29, 8'h04, 1);
    t_simple(24, 8'h20, 4);
    t_simple(23, 8'h52, 4);
    t_simple(22, 8'hC7, 1);
    t_simple(21, 8'hB9, 1);
    t_simple(20, 8'hAB, 1);
    t_simple(19, 8'hA3, 1);
    t_status_id();
    t_prio();
    t_busy();
    t_mark();
    t_user();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule